// File: doc/BRIEF.md
# Two-Road Intersection Signal Controller with Emergency Hold

This block sequences the red, yellow and green lamps of two crossing roads, east-west and north-south. Each road also shows the seconds left in its current lamp phase as a two-digit packed BCD countdown. A one-cycle pulse arriving once per second advances the countdowns. The two roads are offset so that one road's green-plus-yellow time covers exactly the other road's red time. The full cycle lasts 100 seconds, and the two roads are never both allowed to move.

A traffic officer can raise the emergency input at any time. After the input passes through a two-flop synchronizer, every lamp turns red and both countdowns freeze. A per-road display strobe then toggles on every half-second pulse, so the display driver can blink the digits. When the input drops, each road resumes the phase it was in with the count it had, and normal sequencing continues. The one-second and half-second pulses come from outside the block, and seven-segment scanning is done elsewhere.

Top module: `xing_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, east-west shows green with count 8'h45 and north-south shows red with count 8'h50. Both strobes are 1 (visible).
- R2: East-west runs green 45 s, yellow 5 s, red 50 s, then green again. The count drops by one on each accepted tick. On the tick that finds the count at 01, the next phase is entered with its full duration loaded.
- R3: North-south runs red 50 s, green 45 s, yellow 5 s, then red again, on the same ticks as east-west, so the cycle repeats every 100 ticks.
- R4: Each road has exactly one lamp on at any time. The two roads are never green or yellow at the same time.
- R5: Each count is packed BCD, with tens in bits [7:4] and units in bits [3:0], and neither digit exceeds 9.
- R6: The emergency input is sampled through two flip-flops. From the second rising edge after it is first sampled high, all six lamps show red only, with no green or yellow lit. From the second rising edge after it is sampled low, the lamps follow the phases again.
- R7: A tick that arrives while the emergency is in effect is discarded and leaves both counts and phases unchanged.
- R8: Outside emergency, both strobes are held at 1. During emergency, both strobes start at 1 and invert on each half-second pulse.
- R9: After the emergency is released, each road shows the same phase and count it had when the emergency took effect. The next accepted tick continues the sequence from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| tick_half | input | 1 | One-cycle pulse every half second |
| emerg_req | input | 1 | Manual emergency hold request, asynchronous |
| ew_red | output | 1 | East-west red lamp |
| ew_yel | output | 1 | East-west yellow lamp |
| ew_grn | output | 1 | East-west green lamp |
| ns_red | output | 1 | North-south red lamp |
| ns_yel | output | 1 | North-south yellow lamp |
| ns_grn | output | 1 | North-south green lamp |
| ew_count | output | 8 | East-west countdown, packed BCD |
| ns_count | output | 8 | North-south countdown, packed BCD |
| ew_show | output | 1 | East-west digit strobe, 1 = visible |
| ns_show | output | 1 | North-south digit strobe, 1 = visible |

## Verification
- **Tick and half-second results:** a tick or half-second pulse is driven at a falling edge and captured at the next rising edge. The new count, lamps and strobe are therefore checked at the falling edge that follows, one cycle after the pulse.
- **Emergency input:** a change on the emergency input takes effect two rising edges later. The bench waits three full cycles after each change before checking, and sends no tick inside that window.
- **Reference model:** expected lamps and counts come from a bench model of elapsed seconds modulo 100, which advances only on ticks sent while no emergency is active.

// File: rtl/xing_ctrl.sv
module xing_ctrl #(
  parameter int GREEN_S  = 45,
  parameter int YELLOW_S = 5,
  parameter int RED_S    = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1s,
  input  logic       tick_half,
  input  logic       emerg_req,
  output logic       ew_red,
  output logic       ew_yel,
  output logic       ew_grn,
  output logic       ns_red,
  output logic       ns_yel,
  output logic       ns_grn,
  output logic [7:0] ew_count,
  output logic [7:0] ns_count,
  output logic       ew_show,
  output logic       ns_show
);

  function automatic logic [7:0] to_bcd(int v);
    return 8'((((v / 10) % 10) * 16) + (v % 10));
  endfunction

  localparam logic [7:0] G_BCD = to_bcd(GREEN_S);
  localparam logic [7:0] Y_BCD = to_bcd(YELLOW_S);
  localparam logic [7:0] R_BCD = to_bcd(RED_S);
  localparam logic [1:0] PH_G = 2'd0, PH_Y = 2'd1, PH_R = 2'd2;

  function automatic logic [1:0] nxt(logic [1:0] p);
    return (p == PH_G) ? PH_Y : (p == PH_Y) ? PH_R : PH_G;
  endfunction

  function automatic logic [7:0] load(logic [1:0] p);
    return (p == PH_G) ? G_BCD : (p == PH_Y) ? Y_BCD : R_BCD;
  endfunction

  logic       emg_s1, emg_s2, show_q;
  logic [1:0] phase [2];
  logic [7:0] cnt   [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emg_s1 <= 1'b0;
      emg_s2 <= 1'b0;
    end else begin
      emg_s1 <= emerg_req;
      emg_s2 <= emg_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase[0] <= PH_G;
      cnt[0]   <= G_BCD;
      phase[1] <= PH_R;
      cnt[1]   <= R_BCD;
    end else if (tick_1s && !emg_s2) begin
      for (int i = 0; i < 2; i++) begin
        if (cnt[i] == 8'h01) begin
          phase[i] <= nxt(phase[i]);
          cnt[i]   <= load(nxt(phase[i]));
        end else if (cnt[i][3:0] == 4'd0) begin
          cnt[i] <= {cnt[i][7:4] - 4'd1, 4'd9};
        end else begin
          cnt[i] <= cnt[i] - 8'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         show_q <= 1'b1;
    else if (!emg_s2)   show_q <= 1'b1;
    else if (tick_half) show_q <= ~show_q;
  end

  assign ew_grn   = (phase[0] == PH_G) && !emg_s2;
  assign ew_yel   = (phase[0] == PH_Y) && !emg_s2;
  assign ew_red   = (phase[0] == PH_R) || emg_s2;
  assign ns_grn   = (phase[1] == PH_G) && !emg_s2;
  assign ns_yel   = (phase[1] == PH_Y) && !emg_s2;
  assign ns_red   = (phase[1] == PH_R) || emg_s2;
  assign ew_count = cnt[0];
  assign ns_count = cnt[1];
  assign ew_show  = show_q;
  assign ns_show  = show_q;

endmodule

module xing_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       emg_act,
  input logic       ew_red,
  input logic       ew_yel,
  input logic       ew_grn,
  input logic       ns_red,
  input logic       ns_yel,
  input logic       ns_grn,
  input logic [7:0] ew_count,
  input logic [7:0] ns_count,
  input logic       ew_show,
  input logic       ns_show
);

  p_one_lamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ew_red, ew_yel, ew_grn}) == 1 && $countones({ns_red, ns_yel, ns_grn}) == 1);

  p_no_conflict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !((ew_grn || ew_yel) && (ns_grn || ns_yel)));

  p_bcd_digits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ew_count[3:0] <= 4'd9 && ew_count[7:4] <= 4'd9 && ns_count[3:0] <= 4'd9 && ns_count[7:4] <= 4'd9);

  p_all_red_r6: assert property (@(posedge clk) disable iff (!rst_n)
    emg_act |-> (ew_red && ns_red && !ew_grn && !ew_yel && !ns_grn && !ns_yel));

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    emg_act |=> ($stable(ew_count) && $stable(ns_count)));

  p_show_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !emg_act |=> (ew_show && ns_show));

  p_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ew_count != 8'h00 && ns_count != 8'h00);

endmodule

bind xing_ctrl xing_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .emg_act(emg_s2),
  .ew_red(ew_red), .ew_yel(ew_yel), .ew_grn(ew_grn),
  .ns_red(ns_red), .ns_yel(ns_yel), .ns_grn(ns_grn),
  .ew_count(ew_count), .ns_count(ns_count),
  .ew_show(ew_show), .ns_show(ns_show)
);

// File: tb/tb_xing_ctrl.sv
module tb_xing_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_1s = 1'b0, tick_half = 1'b0, emerg_req = 1'b0;
  logic ew_red, ew_yel, ew_grn, ns_red, ns_yel, ns_grn, ew_show, ns_show;
  logic [7:0] ew_count, ns_count;
  int nchk = 0, nfail = 0, t = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xing_ctrl dut (.*);

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic logic [10:0] exp_ew(int s);
    if (s < 45) return {3'b001, bcd(45 - s)};
    if (s < 50) return {3'b010, bcd(50 - s)};
    return {3'b100, bcd(100 - s)};
  endfunction

  function automatic logic [10:0] exp_ns(int s);
    if (s < 50) return {3'b100, bcd(50 - s)};
    if (s < 95) return {3'b001, bcd(95 - s)};
    return {3'b010, bcd(100 - s)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at t=%0d", req, act, expv, t);
    end
  endtask

  task automatic chk_normal(input string req);
    logic [10:0] e, n;
    e = exp_ew(t);
    n = exp_ns(t);
    chk({ew_red, ew_yel, ew_grn, ew_count} == e, {req, " ew"}, {ew_red, ew_yel, ew_grn, ew_count}, e);
    chk({ns_red, ns_yel, ns_grn, ns_count} == n, {req, " ns"}, {ns_red, ns_yel, ns_grn, ns_count}, n);
    chk(ew_show && ns_show, "R8 strobe held", {ew_show, ns_show}, 2'b11);
    chk(!((ew_grn || ew_yel) && (ns_grn || ns_yel)), "R4 exclusion", {ew_grn, ew_yel, ns_grn, ns_yel}, 0);
  endtask

  task automatic do_tick(input int gap);
    @(negedge clk) tick_1s = 1'b1;
    @(negedge clk) tick_1s = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic half_pulse;
    @(negedge clk) tick_half = 1'b1;
    @(negedge clk) tick_half = 1'b0;
  endtask

  task automatic emergency(input int ntick, input int nhalf);
    logic [7:0] ec, nc;
    bit s;
    ec = ew_count;
    nc = ns_count;
    @(negedge clk) emerg_req = 1'b1;
    repeat (3) @(negedge clk);
    chk({ew_red, ew_yel, ew_grn, ns_red, ns_yel, ns_grn} == 6'b100100, "R6 all red",
        {ew_red, ew_yel, ew_grn, ns_red, ns_yel, ns_grn}, 6'b100100);
    chk(ew_show && ns_show, "R8 strobe starts visible", {ew_show, ns_show}, 2'b11);
    for (int k = 0; k < ntick; k++) do_tick(1);
    chk(ew_count == ec && ns_count == nc, "R7 ticks discarded", {ew_count, ns_count}, {ec, nc});
    s = 1'b1;
    for (int k = 0; k < nhalf; k++) begin
      half_pulse();
      s = ~s;
      chk(ew_show == s && ns_show == s, "R8 blink toggle", {ew_show, ns_show}, {s, s});
    end
    @(negedge clk) emerg_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(ew_count == ec && ns_count == nc, "R9 resume count", {ew_count, ns_count}, {ec, nc});
    chk_normal("R9 resume phase");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1d5;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk({ew_grn, ew_count} == {1'b1, 8'h45} && {ns_red, ns_count} == {1'b1, 8'h50},
        "R1 reset state", {ew_grn, ew_count, ns_red, ns_count}, {1'b1, 8'h45, 1'b1, 8'h50});
    chk(ew_show && ns_show, "R1 strobe at reset", {ew_show, ns_show}, 2'b11);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk_normal("R1 after release");

    // R2 R3 R5: a full 100 s cycle plus one more tick
    for (int k = 0; k < 101; k++) begin
      do_tick($urandom_range(0, 3));
      t = (t + 1) % 100;
      chk_normal("R2 R3 R5 cycle");
    end

    // R9: emergency in the middle of east-west yellow (t=47, count 03)
    while (t != 47) begin
      do_tick(0);
      t = (t + 1) % 100;
    end
    chk(ew_yel && ew_count == 8'h03, "R9 setup yellow", {ew_yel, ew_count}, {1'b1, 8'h03});
    emergency(3, 4);
    do_tick(1);
    t = (t + 1) % 100;
    chk_normal("R9 continue after yellow hold");

    // random mix of ticks and emergency episodes
    for (int k = 0; k < 220; k++) begin
      if ($urandom_range(0, 15) == 0) begin
        emergency($urandom_range(0, 3), $urandom_range(0, 5));
      end else begin
        do_tick($urandom_range(0, 4));
        t = (t + 1) % 100;
        chk_normal("R2 R3 R4 random");
      end
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule